// File: doc/BRIEF.md
# Pipelined Low-Precision Dot-Product Unit

This block holds one matrix row of signed 4-bit elements in a local block memory and computes the dot product of that row with a vector streamed in from outside. Each clock it consumes eight element pairs. The products pass through a fixed pipeline: memory read, eight parallel multiplies, a two-level adder tree, and a running accumulator. A one-cycle done strobe then presents the exact signed sum. For an N-element row, the done strobe follows the accepted start by exactly N/8 + 5 clock edges, which is 133 for the default 1024-element row.

The row is written before a computation through a simple port. Each write stores one word holding one beat of eight elements. A caller then pulses start and supplies one vector beat per cycle, with no gaps, in step with the internal row read. Many such units placed side by side, each holding a different row, form a full matrix-vector multiplier. This project covers a single unit.

Top module: `dotprod_row_engine`

## Requirements
- R1: While rst is high and in the cycle after it, done is 0 and result is 0.
- R2: A write with wr_en high stores wr_data as row word wr_addr. Bits [4j+3:4j] of word b hold row element b*LANES+j, as a signed two's complement value. The same lane layout applies to vec_data.
- R3: A start seen while the unit is idle is accepted. done is then high exactly ROW_LEN/LANES + 5 rising edges after the accepting edge, which is 133 for ROW_LEN=1024 and LANES=8. done is not high at any earlier edge.
- R4: Vector beat k (k = 0 .. ROW_LEN/LANES-1) is sampled at rising edge k+1 after the accepting edge. vec_data at any other time has no effect on the result.
- R5: result is the exact signed sum over all elements of row element times vector element. This holds across the full range, including every element at -8. result is ACC_W = 2*ELEM_W + log2(ROW_LEN) + 1 bits wide.
- R6: done is high for exactly one cycle per computation. result changes only on the edge that raises done and holds its value until the next done.
- R7: A start received while a computation is in progress is ignored. It changes neither the result nor the timing of done.
- R8: Each accepted start clears the accumulator, so back-to-back computations do not add together.
- R9: Row contents persist across computations. A second start without any new writes uses the same row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row word write enable |
| wr_addr | input | ADDR_W | Row word index (beat number) |
| wr_data | input | LANES*ELEM_W | Eight packed signed row elements |
| start | input | 1 | Begin a computation (ignored while busy) |
| vec_data | input | LANES*ELEM_W | Eight packed signed vector elements per beat |
| done | output | 1 | One-cycle strobe with the final sum |
| result | output | ACC_W | Signed dot product, held between strobes |

## Verification
The bench builds two copies. The first has ROW_LEN=64 and LANES=8, so one computation takes 13 cycles. Four computations then cover all 256 signed 4-bit operand pairs, and a few further runs cover the extremes, ignored starts, cleared accumulation and reuse of the row. The second copy uses the default 1024-element row with every operand at -8. This pins the 133-cycle latency and drives the accumulator to its largest magnitude of 65536.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // Sequencer phases: waiting, streaming the row out, draining the pipe.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  // Edges between the last row read and the done strobe
  // (multiply, tree level 1, tree level 2, accumulate, result register).
  localparam int TAIL_EDGES = 5;
endpackage

// File: rtl/dp_row_mem.sv
module dp_row_mem #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/dp_seq.sv
module dp_seq
  import dp_pkg::*;
#(
  parameter int BEATS  = 128,
  parameter int ADDR_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              finish,
  output logic              busy,
  output logic              accept,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_last
);
  seq_state_e        st;
  logic [ADDR_W-1:0] beat_cnt;
  logic              row_end;

  assign busy    = (st != SEQ_IDLE);
  assign accept  = start && (st == SEQ_IDLE);
  assign rd_en   = (st == SEQ_READ);
  assign rd_addr = beat_cnt;
  assign row_end = (beat_cnt == ADDR_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      beat_cnt <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_last  <= rd_en && row_end;
      case (st)
        SEQ_IDLE: begin
          beat_cnt <= '0;
          if (start) st <= SEQ_READ;
        end
        SEQ_READ: begin
          beat_cnt <= beat_cnt + 1'b1;
          if (row_end) st <= SEQ_DRAIN;
        end
        SEQ_DRAIN: begin
          if (finish) st <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dp_mac_tree.sv
module dp_mac_tree #(
  parameter int ELEM_W = 4,
  parameter int LANES  = 8,
  parameter int PROD_W = 2 * ELEM_W,
  parameter int SUM_W  = PROD_W + $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [LANES*ELEM_W-1:0] a_word,
  input  logic [LANES*ELEM_W-1:0] b_word,
  output logic                    out_valid,
  output logic                    out_last,
  output logic signed [SUM_W-1:0] out_sum
);
  localparam int PAIRS  = LANES / 2;
  localparam int PAIR_W = PROD_W + 1;

  logic [LANES*PROD_W-1:0] prod_d, prod_q;
  logic [PAIRS*PAIR_W-1:0] pair_d, pair_q;
  logic [PAIRS*SUM_W-1:0]  pair_ext;
  logic signed [SUM_W-1:0] total_d;
  logic                    v_mul, v_pair, l_mul, l_pair;

  // Stage: one signed multiplier per lane.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [ELEM_W-1:0]        a_raw, b_raw;
    logic signed [PROD_W-1:0] a_ext, b_ext, prod;
    assign a_raw = a_word[ln*ELEM_W +: ELEM_W];
    assign b_raw = b_word[ln*ELEM_W +: ELEM_W];
    assign a_ext = {{(PROD_W-ELEM_W){a_raw[ELEM_W-1]}}, a_raw};
    assign b_ext = {{(PROD_W-ELEM_W){b_raw[ELEM_W-1]}}, b_raw};
    assign prod  = a_ext * b_ext;
    assign prod_d[ln*PROD_W +: PROD_W] = prod;
  end

  // Tree level 1: neighbouring lanes summed in pairs.
  for (genvar pr = 0; pr < PAIRS; pr++) begin : g_pair
    logic [PROD_W-1:0]        lo_raw, hi_raw;
    logic signed [PAIR_W-1:0] lo_ext, hi_ext;
    logic [PAIR_W-1:0]        pq;
    assign lo_raw = prod_q[(2*pr)*PROD_W +: PROD_W];
    assign hi_raw = prod_q[(2*pr+1)*PROD_W +: PROD_W];
    assign lo_ext = {lo_raw[PROD_W-1], lo_raw};
    assign hi_ext = {hi_raw[PROD_W-1], hi_raw};
    assign pair_d[pr*PAIR_W +: PAIR_W] = lo_ext + hi_ext;
    assign pq = pair_q[pr*PAIR_W +: PAIR_W];
    assign pair_ext[pr*SUM_W +: SUM_W] = {{(SUM_W-PAIR_W){pq[PAIR_W-1]}}, pq};
  end

  // Tree level 2: all pair sums folded into one beat sum.
  always_comb begin
    total_d = '0;
    for (int pr = 0; pr < PAIRS; pr++) begin
      total_d = total_d + $signed(pair_ext[pr*SUM_W +: SUM_W]);
    end
  end

  always_ff @(posedge clk) begin
    prod_q  <= prod_d;
    pair_q  <= pair_d;
    out_sum <= total_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_mul     <= 1'b0;
      v_pair    <= 1'b0;
      out_valid <= 1'b0;
      l_mul     <= 1'b0;
      l_pair    <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      v_mul     <= in_valid;
      v_pair    <= v_mul;
      out_valid <= v_pair;
      l_mul     <= in_valid && in_last;
      l_pair    <= l_mul;
      out_last  <= l_pair;
    end
  end
endmodule

// File: rtl/dotprod_row_engine.sv
module dotprod_row_engine
  import dp_pkg::*;
#(
  parameter int ELEM_W  = 4,
  parameter int LANES   = 8,
  parameter int ROW_LEN = 1024,
  parameter int ADDR_W  = $clog2(ROW_LEN / LANES),
  parameter int ACC_W   = 2 * ELEM_W + $clog2(ROW_LEN) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*ELEM_W-1:0] wr_data,
  input  logic                    start,
  input  logic [LANES*ELEM_W-1:0] vec_data,
  output logic                    done,
  output logic signed [ACC_W-1:0] result
);
  localparam int BEATS  = ROW_LEN / LANES;
  localparam int WORD_W = LANES * ELEM_W;
  localparam int PROD_W = 2 * ELEM_W;
  localparam int SUM_W  = PROD_W + $clog2(LANES);
  localparam int LAT    = BEATS + TAIL_EDGES;

  logic              busy, accept, rd_en, rd_valid, rd_last;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] row_word, vec_q;
  logic              tree_valid, tree_last;
  logic signed [SUM_W-1:0] tree_sum;
  logic signed [ACC_W-1:0] acc, tree_ext;
  logic              acc_last;

  dp_seq #(.BEATS(BEATS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .finish(acc_last),
    .busy(busy), .accept(accept), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_last(rd_last)
  );

  dp_row_mem #(.WORD_W(WORD_W), .DEPTH(BEATS), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(row_word)
  );

  // Vector beat captured on the same edge as the matching row word.
  always_ff @(posedge clk) begin
    if (rd_en) vec_q <= vec_data;
  end

  dp_mac_tree #(.ELEM_W(ELEM_W), .LANES(LANES), .PROD_W(PROD_W), .SUM_W(SUM_W)) u_tree (
    .clk(clk), .rst(rst), .in_valid(rd_valid), .in_last(rd_last),
    .a_word(row_word), .b_word(vec_q),
    .out_valid(tree_valid), .out_last(tree_last), .out_sum(tree_sum)
  );

  assign tree_ext = {{(ACC_W-SUM_W){tree_sum[SUM_W-1]}}, tree_sum};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      acc_last <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      if (accept)          acc <= '0;
      else if (tree_valid) acc <= acc + tree_ext;
      acc_last <= tree_valid && tree_last;
      done     <= acc_last;
      if (acc_last) result <= acc;
    end
  end
endmodule

// File: rtl/dotprod_row_engine_chk.sv
module dotprod_row_engine_chk #(
  parameter int LAT   = 133,
  parameter int RES_W = 19
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic signed [RES_W-1:0] result
);
  localparam int CW = $clog2(LAT + 2);
  logic [CW-1:0] since;

  // Edges since the accepting edge, plus one; saturates at LAT+1.
  always_ff @(posedge clk) begin
    if (rst)                                since <= '0;
    else if (start && !busy)                since <= CW'(1);
    else if (done)                          since <= '0;
    else if (since != 0 && since != CW'(LAT + 1)) since <= since + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && result == '0)); // R1
  AST_EXACT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (since == CW'(LAT + 1))); // R3
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R6
endmodule

bind dotprod_row_engine dotprod_row_engine_chk #(.LAT(LAT), .RES_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/dotprod_row_engine_bench.sv
module dotprod_row_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EW      = 4;
  localparam int NL      = 8;
  localparam int S_LEN   = 64;
  localparam int S_BEATS = S_LEN / NL;
  localparam int S_LAT   = S_BEATS + 5;
  localparam int S_AW    = $clog2(S_BEATS);
  localparam int S_ACCW  = 2 * EW + $clog2(S_LEN) + 1;
  localparam int F_LEN   = 1024;
  localparam int F_BEATS = F_LEN / NL;
  localparam int F_LAT   = F_BEATS + 5;
  localparam int F_AW    = $clog2(F_BEATS);
  localparam int F_ACCW  = 2 * EW + $clog2(F_LEN) + 1;
  localparam int WW      = NL * EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              s_wr_en = 1'b0, s_start = 1'b0;
  logic [S_AW-1:0]   s_wr_addr = '0;
  logic [WW-1:0]     s_wr_data = '0, s_vec = '0;
  logic              s_done;
  logic signed [S_ACCW-1:0] s_result;

  logic              f_wr_en = 1'b0, f_start = 1'b0;
  logic [F_AW-1:0]   f_wr_addr = '0;
  logic [WW-1:0]     f_wr_data = '0, f_vec = '0;
  logic              f_done;
  logic signed [F_ACCW-1:0] f_result;

  dotprod_row_engine #(.ELEM_W(EW), .LANES(NL), .ROW_LEN(S_LEN)) u_dotprod_row_engine (
    .clk(clk), .rst(rst), .wr_en(s_wr_en), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
    .start(s_start), .vec_data(s_vec), .done(s_done), .result(s_result)
  );

  dotprod_row_engine #(.ELEM_W(EW), .LANES(NL), .ROW_LEN(F_LEN)) u_dotprod_row_engine_full (
    .clk(clk), .rst(rst), .wr_en(f_wr_en), .wr_addr(f_wr_addr), .wr_data(f_wr_data),
    .start(f_start), .vec_data(f_vec), .done(f_done), .result(f_result)
  );

  int checks = 0;
  int failures = 0;
  int ra [S_LEN];
  int va [S_LEN];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pack_row(input int b);
    logic [WW-1:0] w;
    for (int j = 0; j < NL; j++) w[j*EW +: EW] = EW'(ra[b*NL + j]);
    return w;
  endfunction

  function automatic logic [WW-1:0] pack_vec(input int b);
    logic [WW-1:0] w;
    for (int j = 0; j < NL; j++) w[j*EW +: EW] = EW'(va[b*NL + j]);
    return w;
  endfunction

  task automatic load_small();
    for (int b = 0; b < S_BEATS; b++) begin
      @(negedge clk);
      s_wr_en = 1'b1; s_wr_addr = S_AW'(b); s_wr_data = pack_row(b);
    end
    @(negedge clk);
    s_wr_en = 1'b0;
  endtask

  // One computation on the small copy; inj > 0 pulses start during the run.
  task automatic run_small(input int inj, input string tag);
    longint exp_sum = 0;
    bit early = 1'b0;
    for (int i = 0; i < S_LEN; i++) exp_sum += longint'(ra[i]) * longint'(va[i]);
    @(negedge clk);
    s_start = 1'b1; s_vec = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    s_start = 1'b0; s_vec = pack_vec(0);
    for (int c = 1; c <= S_LAT; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c < S_BEATS) s_vec = pack_vec(c);
      else             s_vec = 32'h5A5A_5A5A ^ WW'(c);   // R4: ignored beats
      s_start = (c == inj);
      if (c < S_LAT && s_done) early = 1'b1;
    end
    s_start = 1'b0;
    $display("run %s", tag);
    chk(s_done && !early, "R3 done edge", longint'(s_done), 1);
    chk(longint'(s_result) == exp_sum, "R5 R4 sum", longint'(s_result), exp_sum);
    @(posedge clk);
    @(negedge clk);
    chk(!s_done, "R6 pulse width", longint'(s_done), 0);
    repeat (3) @(negedge clk);
    chk(longint'(s_result) == exp_sum, "R6 result hold", longint'(s_result), exp_sum);
  endtask

  bit finished = 1'b0;

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!s_done && s_result == 0, "R1 in reset", longint'(s_result), 0);
    chk(!f_done && f_result == 0, "R1 in reset full", longint'(f_result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!s_done && s_result == 0, "R1 after reset", longint'(s_result), 0);

    // R5 R2: every signed operand pair, 64 per run.
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < S_LEN; i++) begin
        ra[i] = ((r * S_LEN + i) >> 4) - 8;
        va[i] = ((r * S_LEN + i) & 15) - 8;
      end
      load_small();
      run_small(0, "sweep");
    end

    // R5: extremes.
    for (int i = 0; i < S_LEN; i++) begin ra[i] = -8; va[i] = -8; end
    load_small();
    run_small(0, "max positive");
    for (int i = 0; i < S_LEN; i++) va[i] = 7;
    run_small(0, "max negative");   // R9: row not reloaded

    // R7: start pulses while busy.
    for (int i = 0; i < S_LEN; i++) begin ra[i] = (i % 15) - 7; va[i] = 3 - (i % 7); end
    load_small();
    run_small(2, "start mid-run");
    run_small(S_LAT - 2, "start late in run");

    // R8: same inputs twice, no summing across runs.
    for (int i = 0; i < S_LEN; i++) va[i] = 1;
    run_small(0, "repeat a");
    run_small(0, "repeat b");

    // R3 R5 on the full-size row: all -8 times all -8 gives 65536.
    for (int b = 0; b < F_BEATS; b++) begin
      @(negedge clk);
      f_wr_en = 1'b1; f_wr_addr = F_AW'(b); f_wr_data = 32'h8888_8888;
    end
    @(negedge clk);
    f_wr_en = 1'b0; f_vec = 32'h8888_8888; f_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    f_start = 1'b0;
    begin
      bit f_early = 1'b0;
      for (int c = 1; c <= F_LAT; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (c < F_LAT && f_done) f_early = 1'b1;
      end
      chk(f_done && !f_early, "R3 full latency 133", longint'(f_done), 1);
      chk(longint'(f_result) == 65536, "R5 full max", longint'(f_result), 65536);
    end
    @(negedge clk);
    chk(!f_done, "R6 full pulse", longint'(f_done), 0);
    finish_up();
  end
endmodule